// File: doc/BRIEF.md
# Multiplexed DRAM Address Bus Driver

This block drives a 16-bit bus that is shared, over time, between two address phases and one data phase on its way to a DRAM memory controller. For each accepted request it builds a 24-bit word address from one of two sources. The data-address source joins a high byte, a middle byte and a low byte. The fetch source joins a 16-bit page number with a displacement whose lowest bit is forced to zero, because every fetch reads a double word.

The block then sends the address in two steps. The row step carries the bank bit, the three chip-select bits and the nine row bits. It also carries the one column bit that the receiver must keep for later. The column step carries the remaining eight column bits. The address bits are permuted so that the DRAM's four-access nibble burst, selected by {column bit 8, row bit 8}, returns four consecutive words. After the two address phases there is one data phase. The bus carries the write data for a write and is released for a read.

The driver accepts a new request during the data phase of the previous one, so transfers can run back to back with no idle cycle between them.

Top module: `mab_driver`

## Requirements
- R1: While reset is held and after it is released, phase_oh is 4'b0001 (idle), bus_oe is 0, bus_out is 0 and req_ready is 1.
- R2: An accepted request is followed by exactly one cycle in each of the row phase (phase_oh 4'b0010), the column phase (4'b0100) and the data phase (4'b1000), in that order. The block then returns to idle unless a new request is accepted. phase_oh is always one-hot.
- R3: With req_sel_pc = 0 the word address W[23:0] is {hi_byte, mid_byte, lo_byte}.
- R4: With req_sel_pc = 1, W = {pc_page, pc_disp[7:1], 1'b0}. pc_disp[0] has no effect on the bus.
- R5: In the row phase, bus_out[15] = W[21] (bank), bus_out[14:12] = W[20:18] (chip select), bus_out[11:10] = 0, bus_out[9] = W[1] (column bit 8, held by the receiver), bus_out[8] = W[0] (row bit 8) and bus_out[7:0] = W[9:2] (row bits 7..0).
- R6: In the column phase, bus_out[15:8] = 0 and bus_out[7:0] = W[17:10] (column bits 7..0).
- R7: Four addresses that differ only in W[1:0] produce identical row bits 7..0 and column bits 7..0. The nibble index {bus_out[9], bus_out[8]} of the row phase equals W[1:0], so a burst returns words n..n+3.
- R8: bus_oe is 1 in both address phases. In the data phase, a write gives bus_oe = 1 with bus_out = the write data, and a read gives bus_oe = 0 with bus_out = 0.
- R9: req_ready is 1 only in idle and in the data phase. A request presented in the row or column phase has no effect on the transfer in progress.
- R10: A request accepted in the data phase moves the block straight to the row phase of the new address on the next cycle.
- R11: W[23:22] are not sent. hi_byte[7:6] has no effect on the bus.
- R12: Write data is captured when the request is accepted. Later changes to wr_data do not alter the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel_pc | input | 1 | 0 selects the byte source, 1 selects the fetch source |
| req_write | input | 1 | 1 for a write, 0 for a read |
| hi_byte | input | 8 | Top byte of the data address |
| mid_byte | input | 8 | Middle byte of the data address |
| lo_byte | input | 8 | Low byte of the data address |
| pc_page | input | 16 | Fetch page number |
| pc_disp | input | 8 | Fetch displacement (bit 0 ignored) |
| wr_data | input | 16 | Write data |
| bus_out | output | 16 | Multiplexed address/data bus value |
| bus_oe | output | 1 | Bus drive enable |
| phase_oh | output | 4 | One-hot phase: [0] idle, [1] row, [2] column, [3] data |

## Verification
The two functions that can share a cycle are the data phase of one transfer and the acceptance of the next request. The bench provokes this by holding req_valid with a fresh address through the data phase of a write. It checks that the same cycle shows the old write data on the bus, and that the next cycle shows the new row word. A second overlap is a request raised during the address phases. The bench judges it by the column word and data phase, which must still belong to the first transfer.

// File: rtl/mab_pkg.sv
package mab_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  localparam int PH_N = 4;
endpackage

// File: rtl/mab_src.sv
module mab_src #(
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 16
) (
  input  logic                    sel_pc,
  input  logic [BYTE_W-1:0]       hi_b,
  input  logic [BYTE_W-1:0]       mid_b,
  input  logic [BYTE_W-1:0]       lo_b,
  input  logic [PAGE_W-1:0]       page,
  input  logic [3*BYTE_W-PAGE_W-1:0] disp,
  output logic [3*BYTE_W-1:0]     word
);
  localparam int ADDR_W = 3 * BYTE_W;
  localparam int DISP_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] data_word;
  logic [ADDR_W-1:0] fetch_word;
  logic              unused_disp_lsb;

  // Fetches read double words: the displacement's lowest bit never leaves.
  assign unused_disp_lsb = disp[0];
  assign data_word  = {hi_b, mid_b, lo_b};
  assign fetch_word = {page, disp[DISP_W-1:1], 1'b0};

  always_comb begin
    if (sel_pc) word = fetch_word;
    else        word = data_word;
  end
endmodule

// File: rtl/mab_perm.sv
module mab_perm #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16,
  parameter int ROW_W  = 9,
  parameter int CS_W   = 3
) (
  input  logic [ADDR_W-1:0] word,
  output logic [BUS_W-1:0]  row_word,
  output logic [BUS_W-1:0]  col_word
);
  localparam int LOW_W    = ROW_W - 1;          // row/col bits below the nibble bit
  localparam int ROW_BASE = 2;                  // W[1:0] pick the nibble
  localparam int COL_BASE = ROW_BASE + LOW_W;
  localparam int CS_BASE  = COL_BASE + LOW_W;
  localparam int BANK_BIT = CS_BASE + CS_W;
  localparam int CS_POS   = BUS_W - 1 - CS_W;   // lowest bus bit of chip select
  localparam int GAP_LO   = LOW_W + 2;
  localparam int GAP_W    = CS_POS - GAP_LO;

  logic unused_top;
  assign unused_top = ^word[ADDR_W-1:BANK_BIT+1];

  genvar gi;
  generate
    for (gi = 0; gi < LOW_W; gi++) begin : g_low
      assign row_word[gi] = word[ROW_BASE + gi];
      assign col_word[gi] = word[COL_BASE + gi];
    end
    for (gi = 0; gi < CS_W; gi++) begin : g_cs
      assign row_word[CS_POS + gi] = word[CS_BASE + gi];
    end
    if (GAP_W > 0) begin : g_gap
      assign row_word[GAP_LO +: GAP_W] = '0;
    end
  endgenerate

  // Nibble index {col8,row8} = W[1:0]; col8 rides early and is held by the receiver.
  assign row_word[LOW_W]     = word[0];
  assign row_word[LOW_W + 1] = word[1];
  assign row_word[BUS_W-1]   = word[BANK_BIT];
  assign col_word[BUS_W-1:LOW_W] = '0;
endmodule

// File: rtl/mab_seq.sv
module mab_seq
  import mab_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                ready,
  output logic                accept,
  output phase_e              phase,
  output logic [PH_N-1:0]     phase_oh
);
  phase_e phase_q, phase_d;

  assign ready  = (phase_q == PH_IDLE) || (phase_q == PH_DATA);
  assign accept = req_valid && ready;
  assign phase  = phase_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_ROW;
      PH_ROW:  phase_d = PH_COL;
      PH_COL:  phase_d = PH_DATA;
      PH_DATA: phase_d = accept ? PH_ROW : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_comb begin
    phase_oh = '0;
    case (phase_q)
      PH_IDLE: phase_oh[0] = 1'b1;
      PH_ROW:  phase_oh[1] = 1'b1;
      PH_COL:  phase_oh[2] = 1'b1;
      PH_DATA: phase_oh[3] = 1'b1;
      default: phase_oh    = '0;
    endcase
  end

  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_oh) == 1);
  assert_row_then_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[1] |=> phase_oh[2]);
  assert_col_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[2] |=> phase_oh[3]);
  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[0] && !req_valid) |=> phase_oh[0]);
  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[3] && req_valid) |=> phase_oh[1]);
endmodule

// File: rtl/mab_driver.sv
module mab_driver
  import mab_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 16,
  parameter int BUS_W  = 16,
  parameter int ROW_W  = 9,
  parameter int CS_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_sel_pc,
  input  logic                         req_write,
  input  logic [BYTE_W-1:0]            hi_byte,
  input  logic [BYTE_W-1:0]            mid_byte,
  input  logic [BYTE_W-1:0]            lo_byte,
  input  logic [PAGE_W-1:0]            pc_page,
  input  logic [3*BYTE_W-PAGE_W-1:0]   pc_disp,
  input  logic [BUS_W-1:0]             wr_data,
  output logic [BUS_W-1:0]             bus_out,
  output logic                         bus_oe,
  output logic [PH_N-1:0]              phase_oh
);
  localparam int ADDR_W = 3 * BYTE_W;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_W-1:0] word;
  logic [BUS_W-1:0]  row_w, col_w;
  logic              accept;
  phase_e            phase;

  mab_src #(.BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) u_src (
    .sel_pc (req_sel_pc),
    .hi_b   (hi_byte),
    .mid_b  (mid_byte),
    .lo_b   (lo_byte),
    .page   (pc_page),
    .disp   (pc_disp),
    .word   (word)
  );

  mab_perm #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .ROW_W(ROW_W), .CS_W(CS_W)) u_perm (
    .word     (word),
    .row_word (row_w),
    .col_word (col_w)
  );

  mab_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .ready     (req_ready),
    .accept    (accept),
    .phase     (phase),
    .phase_oh  (phase_oh)
  );

  // Capture registers: next-state then register, loaded on accept.
  logic [BUS_W-1:0] row_q, row_d, col_q, col_d, wd_q, wd_d;
  logic             wr_q, wr_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    wd_d  = wd_q;
    wr_d  = wr_q;
    if (accept) begin
      row_d = row_w;
      col_d = col_w;
      wd_d  = wr_data;
      wr_d  = req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      row_q <= '0;
      col_q <= '0;
      wd_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      wd_q  <= wd_d;
      wr_q  <= wr_d;
    end
  end

  always_comb begin
    bus_out = '0;
    bus_oe  = 1'b0;
    case (phase)
      PH_ROW:  begin bus_out = row_q; bus_oe = 1'b1; end
      PH_COL:  begin bus_out = col_q; bus_oe = 1'b1; end
      PH_DATA: begin
        bus_oe  = wr_q;
        bus_out = wr_q ? wd_q : '0;
      end
      default: begin bus_out = '0; bus_oe = 1'b0; end
    endcase
  end

  assert_addr_drive_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_oh[1] || phase_oh[2]) |-> bus_oe);
  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_oh[2] && !wr_q) |=> (!bus_oe && bus_out == '0));
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_oh[1] || phase_oh[2]) |-> !req_ready);
  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    phase_oh[1] |=> ($stable(row_q) && $stable(col_q)));
  assert_wdata_held_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    !accept |=> $stable(wd_q));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    phase_oh[0] |-> (!bus_oe && bus_out == '0));
endmodule

// File: tb/mab_driver_tb.sv
module mab_driver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_sel_pc, req_write;
  logic [7:0]  hi_byte, mid_byte, lo_byte, pc_disp;
  logic [15:0] pc_page, wr_data, bus_out;
  logic        bus_oe;
  logic [3:0]  phase_oh;

  int checks = 0;
  int errors = 0;

  mab_driver u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel_pc(req_sel_pc), .req_write(req_write), .hi_byte(hi_byte),
    .mid_byte(mid_byte), .lo_byte(lo_byte), .pc_page(pc_page), .pc_disp(pc_disp),
    .wr_data(wr_data), .bus_out(bus_out), .bus_oe(bus_oe), .phase_oh(phase_oh)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [7:0]  hb;
    logic [7:0]  mb;
    logic [7:0]  lb;
    logic [15:0] pg;
    logic [7:0]  dp;
    logic [15:0] wd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'hA5, 8'h3C, 8'h7E, 16'h0000, 8'h00, 16'hBEEF},
    '{1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 16'h0000, 8'h00, 16'h1234},
    '{1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 16'h8001, 8'h55, 16'h0000},
    '{1'b1, 1'b1, 8'h12, 8'h34, 8'h56, 16'hFFFF, 8'hFF, 16'h0F0F},
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 16'hFFFF},
    '{1'b0, 1'b0, 8'hC0, 8'h01, 8'h03, 16'h7777, 8'h11, 16'h5555}
  };

  // Expected values from the requirement text.
  function automatic logic [23:0] exp_word(vec_t v);
    if (v.sel) return {v.pg, v.dp[7:1], 1'b0};   // R4
    return {v.hb, v.mb, v.lb};                    // R3
  endfunction
  function automatic logic [15:0] exp_row(logic [23:0] w);
    return {w[21], w[20:18], 2'b00, w[1], w[0], w[9:2]};  // R5
  endfunction
  function automatic logic [15:0] exp_col(logic [23:0] w);
    return {8'h00, w[17:10]};                     // R6
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic valid);
    req_valid  = valid;
    req_sel_pc = v.sel;
    req_write  = v.wr;
    hi_byte    = v.hb;
    mid_byte   = v.mb;
    lo_byte    = v.lb;
    pc_page    = v.pg;
    pc_disp    = v.dp;
    wr_data    = v.wd;
  endtask

  logic [15:0] seen_row, seen_col;

  // Called at a negedge with the block idle; ends at the negedge back in idle.
  task automatic run_req(vec_t v, string tag);
    logic [23:0] w;
    w = exp_word(v);
    drive(v, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    seen_row = bus_out;
    chk({tag, " R2 row phase"}, phase_oh, 4'b0010);
    chk({tag, " R5 row word"}, bus_out, exp_row(w));
    chk({tag, " R8 oe row"}, bus_oe, 1'b1);
    @(negedge clk);
    seen_col = bus_out;
    chk({tag, " R2 col phase"}, phase_oh, 4'b0100);
    chk({tag, " R6 col word"}, bus_out, exp_col(w));
    @(negedge clk);
    chk({tag, " R2 data phase"}, phase_oh, 4'b1000);
    chk({tag, " R8 data oe"}, bus_oe, v.wr);
    chk({tag, " R8 data bus"}, bus_out, v.wr ? v.wd : 16'h0000);
    @(negedge clk);
    chk({tag, " R2 back to idle"}, phase_oh, 4'b0001);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v, b;
    logic [15:0] r0, c0;
    rst_n = 1'b0;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase_oh, 4'b0001);
    chk("R1 reset oe", bus_oe, 1'b0);
    chk("R1 reset bus", bus_out, 16'h0000);
    chk("R1 reset ready", req_ready, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release phase", phase_oh, 4'b0001);
    chk("R1 after release bus", bus_out, 16'h0000);

    // Table walk: R3 R4 R5 R6 R8.
    for (int i = 0; i < NV; i++) run_req(VECS[i], $sformatf("vec%0d R3/R4", i));

    // R7: nibble burst neighbours.
    v = VECS[0];
    for (int k = 0; k < 4; k++) begin
      v.lb = {6'b101101, k[1:0]};
      run_req(v, "R7 nibble");
      if (k == 0) begin r0 = seen_row; c0 = seen_col; end
      chk("R7 row bits shared", seen_row[7:0], r0[7:0]);
      chk("R7 col bits shared", seen_col, c0);
      chk("R7 nibble index", {seen_row[9], seen_row[8]}, k[1:0]);
    end

    // R11: top two address bits never sent.
    v = VECS[5]; v.hb = 8'h3F;
    run_req(v, "R11 a"); r0 = seen_row; c0 = seen_col;
    v.hb = 8'hFF;
    run_req(v, "R11 b");
    chk("R11 row unaffected", seen_row, r0);
    chk("R11 col unaffected", seen_col, c0);

    // R4: displacement bit 0 ignored.
    v = VECS[2]; v.dp = 8'h54;
    run_req(v, "R4 even"); r0 = seen_row;
    v.dp = 8'h55;
    run_req(v, "R4 odd");
    chk("R4 disp lsb ignored", seen_row, r0);

    // R9: request during address phases has no effect.
    v = VECS[0]; b = VECS[3];
    drive(v, 1'b1);
    @(negedge clk);
    chk("R9 ready low in row", req_ready, 1'b0);
    drive(b, 1'b1);
    @(negedge clk);
    chk("R9 ready low in col", req_ready, 1'b0);
    chk("R9 col word kept", bus_out, exp_col(exp_word(v)));
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 ready in data", req_ready, 1'b1);
    chk("R9 data kept", bus_out, v.wd);
    @(negedge clk);
    chk("R9 idle after", phase_oh, 4'b0001);

    // R10 + R12: back-to-back, write data changed after accept.
    v = VECS[0]; b = VECS[5];
    drive(v, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    wr_data = 16'hDEAD;
    @(negedge clk);
    @(negedge clk);
    chk("R12 captured write data", bus_out, v.wd);
    chk("R12 write oe", bus_oe, 1'b1);
    drive(b, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 straight to row", phase_oh, 4'b0010);
    chk("R10 new row word", bus_out, exp_row(exp_word(b)));
    @(negedge clk);
    chk("R10 new col word", bus_out, exp_col(exp_word(b)));
    @(negedge clk);
    chk("R10 read data phase oe", bus_oe, 1'b0);
    @(negedge clk);
    chk("R10 idle", phase_oh, 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule